// File: doc/BRIEF.md
# Nibble-Loaded One-Shot Interval Timer

This block counts CPU cycles and raises an interrupt request once a programmed interval has passed. Software builds a 16-bit start value four bits at a time by writing to four address ranges. A write to the control range arms the timer and copies that start value into the counter. From then on, each CPU-cycle tick adds one to the counter. When the counter lands on all ones, the block sets a pending flag and disarms itself.

The pending flag drives the interrupt output. It stays set until software writes to the acknowledge range or to the control range. An acknowledge only lowers the flag: the timer stays disarmed and the counter is not reloaded. To start another interval, software must write the control range again with the arm bit set. Writes outside the six decoded ranges do nothing.

Top module: `irq_interval_timer`

## Requirements
- R1: After reset the start value, counter, arm state and pending flag are all zero, `irq` is low, and ticks alone never raise `irq`.
- R2: A write whose address top nibble is 0x8, 0x9, 0xA or 0xB copies `wr_data[3:0]` into start-value bits [3:0], [7:4], [11:8] or [15:12] respectively. The other start-value bits keep their values, and `wr_data[7:4]` is ignored.
- R3: A write with address top nibble 0xC always clears the pending flag and sets the arm state from `wr_data[1]`. When `wr_data[1]` is 1, it also loads the counter from the start value in the same edge. `wr_data[0]` has no effect.
- R4: A write with address top nibble 0xD clears the pending flag and nothing else. It neither reloads the counter nor changes the arm state.
- R5: On each clock with `tick_en` high while armed, the counter adds one, wrapping from 0xFFFF to 0x0000. When the new value is 0xFFFF, the pending flag sets and the arm state clears. Ticks while disarmed leave the counter unchanged.
- R6: With a start value of 0xFFFC and the timer armed, `irq` is still low after two ticks and is high after the third.
- R7: After a firing and an acknowledge, further ticks never raise `irq` until a control write with `wr_data[1]` = 1. This holds even when the last control write also had `wr_data[0]` = 1.
- R8: `irq` is high exactly while the pending flag is set, active-high.
- R9: When a control or acknowledge write shares a clock edge with a tick that would fire, the write wins and the pending flag ends cleared. A control write also takes the place of that tick.
- R10: Writes whose address top nibble is outside 0x8 to 0xD change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One CPU cycle has elapsed on this clock |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| irq | output | 1 | Interrupt request, high while pending |

## Verification
The situations that are hardest to create from the ports are a register write landing on the same edge as the firing tick, and a full wrap of the counter from 0xFFFF back round to 0xFFFF. The bench drives a write strobe and a tick together on the exact cycle where the counter would reach all ones. It then checks that an acknowledge there leaves the timer silent and disarmed, and that a re-arm there reloads the counter and needs one further tick to fire. The wrap case is covered by arming with a start value of all ones and ticking through all 65,536 steps. A behavioural model in the bench compares `irq` against the design on every clock during every scenario.

// File: rtl/irqtmr_pkg.sv
package irqtmr_pkg;

  // counter geometry
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned NIB_W   = 4;
  localparam int unsigned NIBBLES = CNT_W / NIB_W;
  localparam int unsigned IDX_W   = $clog2(NIBBLES);

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [NIB_W-1:0] nib_t;
  typedef logic [IDX_W-1:0] idx_t;

  // address ranges decoded from the top nibble of the write address
  typedef enum logic [1:0] {
    RGN_NONE  = 2'd0,
    RGN_LATCH = 2'd1,
    RGN_CTRL  = 2'd2,
    RGN_ACK   = 2'd3
  } region_e;

  // one counting step, wraps modulo 2**CNT_W
  function automatic cnt_t step_up(input cnt_t c);
    return c + cnt_t'(1);
  endfunction

  // the firing value is all ones
  function automatic logic is_terminal(input cnt_t c);
    return &c;
  endfunction

  // replace one nibble of a value, keep the rest
  function automatic cnt_t nib_put(input cnt_t cur, input idx_t idx, input nib_t n);
    cnt_t r;
    r = cur;
    r[idx*NIB_W +: NIB_W] = n;
    return r;
  endfunction

  // read one nibble of a value
  function automatic nib_t nib_get(input cnt_t cur, input idx_t idx);
    return cur[idx*NIB_W +: NIB_W];
  endfunction

endpackage

// File: rtl/irqtmr_decode.sv
module irqtmr_decode
  import irqtmr_pkg::*;
(
  input  logic       wr_en,
  input  logic [3:0] top_nib,
  output logic       lat_we,
  output idx_t       lat_idx,
  output logic       ctrl_we,
  output logic       ack_we
);

  region_e rgn;

  always_comb begin
    unique case (top_nib)
      4'h8, 4'h9, 4'hA, 4'hB: rgn = RGN_LATCH;
      4'hC:                   rgn = RGN_CTRL;
      4'hD:                   rgn = RGN_ACK;
      default:                rgn = RGN_NONE;
    endcase
  end

  assign lat_idx = idx_t'(top_nib[1:0]);
  assign lat_we  = wr_en && (rgn == RGN_LATCH);
  assign ctrl_we = wr_en && (rgn == RGN_CTRL);
  assign ack_we  = wr_en && (rgn == RGN_ACK);

endmodule

// File: rtl/irqtmr_latch.sv
module irqtmr_latch
  import irqtmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  idx_t idx,
  input  nib_t nib,
  output cnt_t q
);

  // one independently written register per nibble
  for (genvar g = 0; g < NIBBLES; g++) begin : g_nib
    logic [NIB_W-1:0] r;
    always_ff @(posedge clk) begin
      if (!rst_n)                           r <= '0;
      else if (we && (idx == idx_t'(g)))    r <= nib;
    end
    assign q[g*NIB_W +: NIB_W] = r;
  end

  // R2
  lat_nib_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (nib_get(q, $past(idx)) == $past(nib)));

  // R10
  lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));

endmodule

// File: rtl/irqtmr_core.sv
module irqtmr_core
  import irqtmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ctrl_we,
  input  logic arm_bit,
  input  logic ack_we,
  input  cnt_t start_val,
  output logic pending,
  output logic armed,
  output logic fire
);

  cnt_t count;
  cnt_t count_inc;
  logic advance;

  // events brought out as named wires
  assign advance   = tick && armed && !ctrl_we;
  assign count_inc = step_up(count);
  assign fire      = advance && is_terminal(count_inc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      armed   <= 1'b0;
      pending <= 1'b0;
    end else if (ctrl_we) begin
      armed   <= arm_bit;
      pending <= 1'b0;
      if (arm_bit) count <= start_val;
    end else begin
      if (advance) count <= count_inc;
      if (fire) armed <= 1'b0;
      if (ack_we)    pending <= 1'b0;
      else if (fire) pending <= 1'b1;
    end
  end

  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && arm_bit) |=> (armed && count == $past(start_val)));

  // R3
  disarm_on_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !arm_bit) |=> !armed);

  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we || ctrl_we) |=> !pending);

  // R5
  fire_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !armed);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_we && !(tick && armed)) |=> $stable(count));

  // R9
  set_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> ($past(fire) && !$past(ack_we)));

  // R7
  arm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(ctrl_we && arm_bit));

endmodule

// File: rtl/irq_interval_timer.sv
module irq_interval_timer
  import irqtmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq
);

  localparam int unsigned ARM_BIT = 1;

  logic lat_we, ctrl_we, ack_we;
  idx_t lat_idx;
  cnt_t start_val;
  logic pending, armed, fire;

  irqtmr_decode u_dec (
    .wr_en   (wr_en),
    .top_nib (wr_addr[ADDR_W-1 -: 4]),
    .lat_we  (lat_we),
    .lat_idx (lat_idx),
    .ctrl_we (ctrl_we),
    .ack_we  (ack_we)
  );

  irqtmr_latch u_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (lat_we),
    .idx   (lat_idx),
    .nib   (wr_data[NIB_W-1:0]),
    .q     (start_val)
  );

  irqtmr_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_en),
    .ctrl_we   (ctrl_we),
    .arm_bit   (wr_data[ARM_BIT]),
    .ack_we    (ack_we),
    .start_val (start_val),
    .pending   (pending),
    .armed     (armed),
    .fire      (fire)
  );

  assign irq = pending;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!irq && !armed));

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(fire));

endmodule

// File: tb/irq_interval_timer_test.sv
module irq_interval_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // behavioural reference state
  int m_lat = 0, m_cnt = 0, m_en = 0, m_pend = 0;

  always #10 clk = ~clk;

  irq_interval_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lat = 0; m_cnt = 0; m_en = 0; m_pend = 0;
    end else begin
      int top;
      top = int'(wr_addr) >> 12;
      if (wr_en && top >= 8 && top <= 11) begin
        int sh;
        sh = (top - 8) * 4;
        m_lat = (m_lat & ~(15 << sh)) | ((int'(wr_data) & 15) << sh);
      end
      if (wr_en && top == 12) begin
        m_en = (int'(wr_data) >> 1) & 1;
        if (m_en == 1) m_cnt = m_lat;
        m_pend = 0;
      end else begin
        if (tick_en && m_en == 1) begin
          m_cnt = (m_cnt + 1) % 65536;
          if (m_cnt == 65535) begin
            m_pend = 1;
            m_en = 0;
          end
        end
        if (wr_en && top == 13) m_pend = 0;
      end
    end
  end

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (irq !== m_pend[0]) begin
        failures++;
        $display("FAIL model R5 cycle compare: irq=%0b expected=%0d", irq, m_pend);
      end
    end
  end

  task automatic check_irq(input logic exp, input string tag);
    checks++;
    if (irq !== exp) begin
      failures++;
      $display("FAIL %s: irq=%0b expected=%0b", tag, irq, exp);
    end
  endtask

  task automatic write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic write_with_tick(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_irq(1'b0, "R1 reset state");
    ticks(100);
    check_irq(1'b0, "R1 ticks after reset");

    // start value 0xFFFC, upper data nibble ignored
    write(16'h8000, 8'hFC);
    write(16'h9000, 8'h0F);
    write(16'hA123, 8'h0F);
    write(16'hBFFF, 8'h0F);
    write(16'hC000, 8'h02);
    ticks(2);
    check_irq(1'b0, "R6 two ticks");
    ticks(1);
    check_irq(1'b1, "R6 third tick fires");
    ticks(3);
    check_irq(1'b1, "R8 irq held while pending");
    write(16'hD000, 8'h00);
    check_irq(1'b0, "R4 acknowledge clears");
    ticks(20);
    check_irq(1'b0, "R7 silent after ack");

    // bit 0 set alongside arm bit
    write(16'hC000, 8'h03);
    ticks(2);
    check_irq(1'b0, "R3 bit0 no effect early");
    ticks(1);
    check_irq(1'b1, "R3 bit0 no effect fire");
    write(16'hD000, 8'h00);
    ticks(50);
    check_irq(1'b0, "R7 bit0 does not re-arm");

    // replace only the low nibble
    write(16'h8000, 8'h0D);
    write(16'hC000, 8'h02);
    ticks(1);
    check_irq(1'b0, "R2 partial nibble early");
    ticks(1);
    check_irq(1'b1, "R2 other nibbles kept");
    write(16'hD000, 8'h00);

    // acknowledge mid-interval
    write(16'h8000, 8'h00);
    write(16'hC000, 8'h02);
    ticks(5);
    write(16'hD000, 8'h00);
    ticks(9);
    check_irq(1'b0, "R4 no reload early");
    ticks(1);
    check_irq(1'b1, "R4 ack keeps counter and arm");
    write(16'hC000, 8'h00);
    check_irq(1'b0, "R3 control clears pending");

    // disarm
    write(16'hC000, 8'h02);
    write(16'hC000, 8'h00);
    ticks(40);
    check_irq(1'b0, "R3 disarm by bit1 low");

    // unmapped writes
    write(16'h8000, 8'h0C);
    write(16'hE000, 8'hFF);
    write(16'h4000, 8'hFF);
    write(16'hF000, 8'hFF);
    check_irq(1'b0, "R10 unmapped no irq");
    write(16'hC000, 8'h02);
    write(16'hE000, 8'hFF);
    ticks(2);
    check_irq(1'b0, "R10 unmapped early");
    ticks(1);
    check_irq(1'b1, "R10 start value intact");
    write(16'hD000, 8'h00);

    // same-edge collisions at 0xFFFE
    write(16'h8000, 8'h0E);
    write(16'hC000, 8'h02);
    write_with_tick(16'hD000, 8'h00);
    check_irq(1'b0, "R9 ack beats firing tick");
    ticks(10);
    check_irq(1'b0, "R9 disarmed after collision");
    write(16'hC000, 8'h02);
    write_with_tick(16'hC000, 8'h02);
    check_irq(1'b0, "R9 control beats firing tick");
    ticks(1);
    check_irq(1'b1, "R9 reload needs one more tick");
    write(16'hD000, 8'h00);

    // full wrap from 0xFFFF
    write(16'h8000, 8'h0F);
    write(16'hC000, 8'h02);
    ticks(65535);
    check_irq(1'b0, "R5 wrap not yet");
    ticks(1);
    check_irq(1'b1, "R5 fires after full wrap");

    // reset clears pending
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_irq(1'b0, "R1 reset clears pending");

    finish_run();
  end

endmodule